// File: doc/BRIEF.md
# Priority Interrupt Controller Command Port

This block is the byte-wide programming port of one eight-line priority interrupt controller. It sits between a two-address register window (selected by one address bit) and the controller's request/in-service storage and priority resolver. Writes are decoded into initialization words, mode commands, end-of-interrupt and rotation commands, or mask loads. Reads return the request, in-service or mask register, or, when a poll is armed, the resolver's current candidate line.

The port holds the controller's mode state: mask, vector base, rotation base, read select, poll flag, special mask, auto end-of-interrupt, rotate-on-auto-EOI and nested mode. It drives one-cycle clear strobes toward the in-service and request registers, and a one-cycle init pulse that tells the storage to empty itself and drop the interrupt output. The request and in-service registers live outside the block and come in as inputs. All writes act on the clock edge that samples the write strobe. Read data and clear strobes are combinational in the cycle of the strobe.

Top module: `irc_cmd_port`

## Requirements
- R1: A write at address 0 with data bit 4 set pulses init_o in that cycle. After the edge, mask, vector base, rotation base and every mode flag are 0, and the init sequencer is waiting for the base word.
- R2: The first address-1 write after an init word sets the vector base to data AND 0xF8 and does not change the mask.
- R3: The next address-1 write is a configuration word with no stored content. If bit 0 of the init word was 1, one more address-1 write follows: nested mode takes data bit 4 and auto-EOI takes data bit 1. After that the port is in normal mode. If bit 0 was 0, normal mode starts right after the configuration word.
- R4: In normal mode, an address-1 write loads the mask. Address-1 writes during the init sequence leave the mask unchanged.
- R5: An address-0 write with bit 4 clear and bit 3 set is a mode command. Bit 2 set arms poll. Bit 1 set copies bit 0 into read select. Bit 6 set copies bit 5 into special mask. Flags whose enable bit is clear keep their value.
- R6: Other address-0 writes decode cmd = data[7:5]. Commands 0 and 4 set rotate-on-auto-EOI to data bit 7.
- R7: Command 1 strobes isr_clr_o for the highest-priority in-service line. The search starts at line rot_base and runs upward, wrapping modulo 8. Command 5 does the same and also sets the rotation base to that line + 1 mod 8. With no in-service bit set, neither command strobes anything or changes the rotation base.
- R8: Command 3 strobes isr_clr_o for line data[2:0]. Command 7 does the same and also sets the rotation base to data[2:0] + 1 mod 8. Command 6 only sets the rotation base to data[2:0] + 1 mod 8. Command 2 changes nothing and strobes nothing.
- R9: A read while poll is armed returns the candidate line on rdata_o and strobes both isr_clr_o and irr_clr_o for that line. With no valid candidate it returns 7 and strobes nothing. In either case poll is disarmed after the edge.
- R10: A read without poll returns the mask at address 1. At address 0 it returns the in-service input when read select is 1 and the request input when read select is 0.
- R11: Asynchronous reset puts every output register at 0 and the sequencer in normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a0_i | input | 1 | Register address bit |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| irr_i | input | 8 | Request register contents |
| isr_i | input | 8 | In-service register contents |
| cand_line_i | input | 3 | Resolver candidate line |
| cand_valid_i | input | 1 | Resolver candidate is valid |
| rdata_o | output | 8 | Read data |
| init_o | output | 1 | Init word pulse (clear storage, drop output) |
| mask_o | output | 8 | Interrupt mask |
| vec_base_o | output | 8 | Vector base, low three bits zero |
| rot_base_o | output | 3 | Rotation base (lowest-numbered highest priority line) |
| rsel_o | output | 1 | Read select, 1 = in-service |
| poll_o | output | 1 | Poll armed |
| smm_o | output | 1 | Special mask mode |
| aeoi_o | output | 1 | Automatic end of interrupt |
| rot_aeoi_o | output | 1 | Rotate on automatic end of interrupt |
| nested_o | output | 1 | Nested mode |
| isr_clr_o | output | 8 | In-service clear strobes |
| irr_clr_o | output | 8 | Request clear strobes |

## Verification
The assertions assume that a write and a read never fall in the same cycle. They also assume that the in-service and request inputs change only away from the clock edge. The bench drives every access through a single task that asserts exactly one strobe per cycle and releases it right after the edge. Candidate, request and in-service inputs are set on the falling edge, well before the sampled rising edge.

// File: rtl/irc_pkg.sv
package irc_pkg;
  localparam int LINES = 8;
  localparam int LW    = $clog2(LINES);

  typedef enum logic [1:0] {
    SEQ_RUN  = 2'd0,
    SEQ_BASE = 2'd1,
    SEQ_CFG  = 2'd2,
    SEQ_OPT  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/irc_prio_pick.sv
module irc_prio_pick #(
  parameter int N  = 8,
  localparam int LW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  input  logic [LW-1:0] base_i,
  output logic          found_o,
  output logic [LW-1:0] idx_o,
  output logic [N-1:0]  onehot_o
);
  logic [N-1:0]  rot;
  logic [LW-1:0] off;

  // rot[k] is the line k steps above base
  always_comb begin
    for (int k = 0; k < N; k++) rot[k] = req_i[(k + int'(base_i)) % N];
    found_o = 1'b0;
    off     = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (rot[k]) begin
        found_o = 1'b1;
        off     = LW'(k);
      end
    end
    idx_o    = LW'((int'(off) + int'(base_i)) % N);
    onehot_o = found_o ? (N'(1) << idx_o) : '0;
  end
endmodule

// File: rtl/irc_init_seq.sv
module irc_init_seq
  import irc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          init_w_i,
  input  logic          data_w_i,
  input  logic [DW-1:0] wdata_i,
  output logic          run_o,
  output logic [DW-1:0] vec_base_o,
  output logic          nested_o,
  output logic          aeoi_o
);
  localparam logic [DW-1:0] BASE_MASK = ~DW'(LINES - 1);

  seq_state_e st_q;
  logic       opt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= SEQ_RUN;
      opt_q      <= 1'b0;
      vec_base_o <= '0;
      nested_o   <= 1'b0;
      aeoi_o     <= 1'b0;
    end else if (init_w_i) begin
      st_q       <= SEQ_BASE;
      opt_q      <= wdata_i[0];
      vec_base_o <= '0;
      nested_o   <= 1'b0;
      aeoi_o     <= 1'b0;
    end else if (data_w_i) begin
      unique case (st_q)
        SEQ_BASE: begin
          vec_base_o <= wdata_i & BASE_MASK;
          st_q       <= SEQ_CFG;
        end
        SEQ_CFG: st_q <= opt_q ? SEQ_OPT : SEQ_RUN;
        SEQ_OPT: begin
          nested_o <= wdata_i[4];
          aeoi_o   <= wdata_i[1];
          st_q     <= SEQ_RUN;
        end
        default: ;
      endcase
    end
  end

  assign run_o = (st_q == SEQ_RUN);
endmodule

// File: rtl/irc_ocw_dec.sv
module irc_ocw_dec
  import irc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             cmd_w_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [LINES-1:0] isr_i,
  input  logic [LW-1:0]    rot_base_i,
  output logic [LINES-1:0] isr_clr_o,
  output logic             rot_ld_o,
  output logic [LW-1:0]    rot_val_o,
  output logic             raeoi_ld_o
);
  logic             hp_found;
  logic [LW-1:0]    hp_idx;
  logic [LINES-1:0] hp_onehot;
  logic [2:0]       cmd;
  logic [LW-1:0]    line;

  irc_prio_pick #(.N(LINES)) i_pick (
    .req_i    (isr_i),
    .base_i   (rot_base_i),
    .found_o  (hp_found),
    .idx_o    (hp_idx),
    .onehot_o (hp_onehot)
  );

  assign cmd  = wdata_i[7:5];
  assign line = wdata_i[LW-1:0];

  always_comb begin
    isr_clr_o  = '0;
    rot_ld_o   = 1'b0;
    rot_val_o  = '0;
    raeoi_ld_o = 1'b0;
    if (cmd_w_i) begin
      unique case (cmd)
        3'd0, 3'd4: raeoi_ld_o = 1'b1;
        3'd1: isr_clr_o = hp_onehot;
        3'd5: begin
          isr_clr_o = hp_onehot;
          rot_ld_o  = hp_found;
          rot_val_o = hp_idx + LW'(1);
        end
        3'd3: isr_clr_o = LINES'(1) << line;
        3'd6: begin
          rot_ld_o  = 1'b1;
          rot_val_o = line + LW'(1);
        end
        3'd7: begin
          isr_clr_o = LINES'(1) << line;
          rot_ld_o  = 1'b1;
          rot_val_o = line + LW'(1);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irc_cmd_port.sv
module irc_cmd_port
  import irc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             a0_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [LINES-1:0] irr_i,
  input  logic [LINES-1:0] isr_i,
  input  logic [LW-1:0]    cand_line_i,
  input  logic             cand_valid_i,
  output logic [DW-1:0]    rdata_o,
  output logic             init_o,
  output logic [LINES-1:0] mask_o,
  output logic [DW-1:0]    vec_base_o,
  output logic [LW-1:0]    rot_base_o,
  output logic             rsel_o,
  output logic             poll_o,
  output logic             smm_o,
  output logic             aeoi_o,
  output logic             rot_aeoi_o,
  output logic             nested_o,
  output logic [LINES-1:0] isr_clr_o,
  output logic [LINES-1:0] irr_clr_o
);
  localparam logic [DW-1:0] NO_CAND = DW'(LINES - 1);

  logic             init_w, mode_w, cmd_w, data_w, run;
  logic             poll_rd, poll_hit;
  logic [LINES-1:0] ocw_clr, poll_clr;
  logic             rot_ld, raeoi_ld;
  logic [LW-1:0]    rot_val;

  assign init_w   = wr_i & ~a0_i & wdata_i[4];
  assign mode_w   = wr_i & ~a0_i & ~wdata_i[4] & wdata_i[3];
  assign cmd_w    = wr_i & ~a0_i & ~wdata_i[4] & ~wdata_i[3];
  assign data_w   = wr_i & a0_i;
  assign poll_rd  = rd_i & poll_o;
  assign poll_hit = poll_rd & cand_valid_i;
  assign poll_clr = poll_hit ? (LINES'(1) << cand_line_i) : '0;

  irc_init_seq #(.DW(DW)) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .init_w_i   (init_w),
    .data_w_i   (data_w),
    .wdata_i    (wdata_i),
    .run_o      (run),
    .vec_base_o (vec_base_o),
    .nested_o   (nested_o),
    .aeoi_o     (aeoi_o)
  );

  irc_ocw_dec #(.DW(DW)) i_ocw (
    .cmd_w_i    (cmd_w),
    .wdata_i    (wdata_i),
    .isr_i      (isr_i),
    .rot_base_i (rot_base_o),
    .isr_clr_o  (ocw_clr),
    .rot_ld_o   (rot_ld),
    .rot_val_o  (rot_val),
    .raeoi_ld_o (raeoi_ld)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o     <= '0;
      rot_base_o <= '0;
      rsel_o     <= 1'b0;
      poll_o     <= 1'b0;
      smm_o      <= 1'b0;
      rot_aeoi_o <= 1'b0;
    end else if (init_w) begin
      mask_o     <= '0;
      rot_base_o <= '0;
      rsel_o     <= 1'b0;
      poll_o     <= 1'b0;
      smm_o      <= 1'b0;
      rot_aeoi_o <= 1'b0;
    end else begin
      if (data_w && run) mask_o <= wdata_i[LINES-1:0];
      if (rot_ld)        rot_base_o <= rot_val;
      if (raeoi_ld)      rot_aeoi_o <= wdata_i[7];
      if (mode_w) begin
        if (wdata_i[2]) poll_o <= 1'b1;
        if (wdata_i[1]) rsel_o <= wdata_i[0];
        if (wdata_i[6]) smm_o  <= wdata_i[5];
      end
      if (poll_rd) poll_o <= 1'b0;
    end
  end

  always_comb begin
    if (poll_o)    rdata_o = poll_hit ? DW'(cand_line_i) : NO_CAND;
    else if (a0_i) rdata_o = DW'(mask_o);
    else if (rsel_o) rdata_o = DW'(isr_i);
    else           rdata_o = DW'(irr_i);
  end

  assign init_o    = init_w;
  assign isr_clr_o = ocw_clr | poll_clr;
  assign irr_clr_o = poll_clr;
endmodule

// File: rtl/irc_cmd_port_chk.sv
module irc_cmd_port_chk #(
  parameter int N = 8,
  localparam int LW = $clog2(N)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          a0_i,
  input logic          wr_i,
  input logic          rd_i,
  input logic [7:0]    wdata_i,
  input logic          cand_valid_i,
  input logic [7:0]    rdata_o,
  input logic [N-1:0]  mask_o,
  input logic [7:0]    vec_base_o,
  input logic [LW-1:0] rot_base_o,
  input logic          poll_o,
  input logic          aeoi_o,
  input logic          nested_o,
  input logic          rot_aeoi_o,
  input logic [N-1:0]  isr_clr_o,
  input logic [N-1:0]  irr_clr_o
);
  a_r1_init_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !a0_i && wdata_i[4] |=> mask_o == '0 && rot_base_o == '0 && vec_base_o == '0
      && !poll_o && !aeoi_o && !nested_o && !rot_aeoi_o);

  a_r2_base_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_base_o[2:0] == 3'd0);

  a_r6_raeoi_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !a0_i && wdata_i[4:3] == 2'b00 && wdata_i[6:5] == 2'b00 |=> rot_aeoi_o == $past(wdata_i[7]));

  a_r7_clr_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(isr_clr_o));

  a_r8_rotate_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !a0_i && wdata_i[7:3] == 5'b11000 |=> rot_base_o == LW'($past(wdata_i[2:0]) + 3'd1));

  a_r9_poll_disarm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !wr_i && poll_o |=> !poll_o);

  a_r9_poll_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && poll_o && !cand_valid_i |-> rdata_o == 8'd7 && irr_clr_o == '0 && isr_clr_o == '0);

  a_r10_mask_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !poll_o && a0_i |-> rdata_o == 8'(mask_o));
endmodule

bind irc_cmd_port irc_cmd_port_chk #(.N(irc_pkg::LINES)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .a0_i         (a0_i),
  .wr_i         (wr_i),
  .rd_i         (rd_i),
  .wdata_i      (wdata_i),
  .cand_valid_i (cand_valid_i),
  .rdata_o      (rdata_o),
  .mask_o       (mask_o),
  .vec_base_o   (vec_base_o),
  .rot_base_o   (rot_base_o),
  .poll_o       (poll_o),
  .aeoi_o       (aeoi_o),
  .nested_o     (nested_o),
  .rot_aeoi_o   (rot_aeoi_o),
  .isr_clr_o    (isr_clr_o),
  .irr_clr_o    (irr_clr_o)
);

// File: tb/test_irc_cmd_port.sv
`timescale 1ns/1ps
module test_irc_cmd_port;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       a0_i = 1'b0, wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0] wdata_i = '0, irr_i = '0, isr_i = '0;
  logic [2:0] cand_line_i = '0;
  logic       cand_valid_i = 1'b0;
  logic [7:0] rdata_o, mask_o, vec_base_o, isr_clr_o, irr_clr_o;
  logic [2:0] rot_base_o;
  logic       init_o, rsel_o, poll_o, smm_o, aeoi_o, rot_aeoi_o, nested_o;

  int n_chk = 0, n_fail = 0;
  logic [7:0] s_rdata, s_isr_clr, s_irr_clr;
  logic       s_init;

  always #2.5 clk_i = ~clk_i;

  irc_cmd_port i_irc_cmd_port (.*);

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input logic w, input logic r, input logic a0, input logic [7:0] d);
    @(negedge clk_i);
    wr_i = w; rd_i = r; a0_i = a0; wdata_i = d;
    #1;
    s_rdata = rdata_o; s_isr_clr = isr_clr_o; s_irr_clr = irr_clr_o; s_init = init_o;
    @(posedge clk_i);
    #1;
    wr_i = 1'b0; rd_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic logic [7:0] hp_line(input logic [7:0] pat, input logic [2:0] base);
    for (int k = 0; k < 8; k++)
      if (pat[(base + k) % 8]) return 8'(1) << ((base + k) % 8);
    return 8'h00;
  endfunction

  initial begin
    #(5.0 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic p, rs, sm;
    #12 rst_ni = 1'b1;
    // R11 reset state
    chk("R11", "regs", {mask_o, vec_base_o, 5'(rot_base_o), rsel_o, poll_o, smm_o, aeoi_o, rot_aeoi_o, nested_o},
        32'h0);

    // dirty state, then init sweep R1..R4
    for (int opt = 0; opt < 2; opt++) begin
      for (int vb = 0; vb < 256; vb += 37) begin
        cyc(1, 0, 1, 8'h5A);               // mask load in run mode
        cyc(1, 0, 0, 8'hC2);               // rotate base -> 3
        cyc(1, 0, 0, 8'h80);               // rot_aeoi = 1
        cyc(1, 0, 0, 8'h6F);               // poll, rsel=1, smm=1
        cyc(1, 0, 0, 8'h10 | 8'(opt));
        chk("R1", "init pulse", s_init, 1);
        chk("R1", "cleared", {mask_o, vec_base_o, 5'(rot_base_o), rsel_o, poll_o, smm_o, aeoi_o, rot_aeoi_o, nested_o}, 0);
        cyc(1, 0, 1, 8'(vb));
        chk("R2", "vec base", vec_base_o, vb & 8'hF8);
        chk("R4", "mask held in init", mask_o, 0);
        cyc(1, 0, 1, 8'hFF);
        chk("R3", "cfg word no mask", mask_o, 0);
        if (opt == 1) begin
          cyc(1, 0, 1, 8'(vb) ^ 8'h12);
          chk("R3", "nested", nested_o, ((vb ^ 8'h12) >> 4) & 1);
          chk("R3", "aeoi", aeoi_o, ((vb ^ 8'h12) >> 1) & 1);
          chk("R4", "mask held opt", mask_o, 0);
        end
        cyc(1, 0, 1, 8'(vb) ^ 8'hA5);
        chk("R4", "mask load", mask_o, vb ^ 8'hA5);
      end
    end

    // R5 mode command sweep
    p = poll_o; rs = rsel_o; sm = smm_o;
    for (int v = 0; v < 256; v++) begin
      if (v[4] == 1'b0 && v[3] == 1'b1) begin
        cyc(1, 0, 0, 8'(v));
        if (v[2]) p = 1'b1;
        if (v[1]) rs = v[0];
        if (v[6]) sm = v[5];
        chk("R5", "poll", poll_o, p);
        chk("R5", "rsel", rsel_o, rs);
        chk("R5", "smm", smm_o, sm);
      end
    end

    // R9 poll reads
    for (int ln = 0; ln < 8; ln++) begin
      cyc(1, 0, 0, 8'h0C);
      cand_line_i = 3'(ln); cand_valid_i = 1'b1;
      cyc(0, 1, ln[0], 8'h00);
      chk("R9", "poll line", s_rdata, ln);
      chk("R9", "isr clr", s_isr_clr, 8'(1) << ln);
      chk("R9", "irr clr", s_irr_clr, 8'(1) << ln);
      chk("R9", "disarm", poll_o, 0);
    end
    cyc(1, 0, 0, 8'h0C);
    cand_valid_i = 1'b0;
    cyc(0, 1, 0, 8'h00);
    chk("R9", "empty poll", s_rdata, 7);
    chk("R9", "empty strobes", {s_isr_clr, s_irr_clr}, 0);
    chk("R9", "empty disarm", poll_o, 0);

    // R10 plain reads
    cyc(1, 0, 1, 8'h3C);
    for (int pat = 0; pat < 256; pat += 17) begin
      irr_i = 8'(pat); isr_i = ~8'(pat);
      cyc(1, 0, 0, 8'h0A);
      cyc(0, 1, 0, 8'h00);
      chk("R10", "irr read", s_rdata, pat);
      cyc(1, 0, 0, 8'h0B);
      cyc(0, 1, 0, 8'h00);
      chk("R10", "isr read", s_rdata, (~pat) & 8'hFF);
      cyc(0, 1, 1, 8'h00);
      chk("R10", "mask read", s_rdata, 8'h3C);
    end

    // R6 rotate-on-auto-EOI
    cyc(1, 0, 0, 8'h80);
    chk("R6", "cmd4 set", rot_aeoi_o, 1);
    cyc(1, 0, 0, 8'h00);
    chk("R6", "cmd0 clear", rot_aeoi_o, 0);

    // R7 non-specific EOI over all bases and patterns
    for (int r = 0; r < 8; r++) begin
      for (int pat = 0; pat < 256; pat++) begin
        isr_i = 8'(pat);
        cyc(1, 0, 0, 8'hC0 | 8'((r + 7) % 8));
        cyc(1, 0, 0, 8'h20);
        chk("R7", "eoi clr", s_isr_clr, hp_line(8'(pat), 3'(r)));
        chk("R7", "eoi keeps base", rot_base_o, r);
        cyc(1, 0, 0, 8'hA0);
        chk("R7", "rot eoi clr", s_isr_clr, hp_line(8'(pat), 3'(r)));
        if (pat == 0) chk("R7", "empty base", rot_base_o, r);
        else begin
          for (int k = 0; k < 8; k++)
            if (hp_line(8'(pat), 3'(r))[k]) chk("R7", "rot base", rot_base_o, (k + 1) % 8);
        end
      end
    end

    // R8 specific commands
    isr_i = 8'hFF;
    for (int ln = 0; ln < 8; ln++) begin
      cyc(1, 0, 0, 8'hC0 | 8'(ln));
      chk("R8", "cmd6 base", rot_base_o, (ln + 1) % 8);
      chk("R8", "cmd6 no clr", s_isr_clr, 0);
      cyc(1, 0, 0, 8'h60 | 8'(ln));
      chk("R8", "cmd3 clr", s_isr_clr, 8'(1) << ln);
      chk("R8", "cmd3 base", rot_base_o, (ln + 1) % 8);
      cyc(1, 0, 0, 8'hE0 | 8'((ln + 3) % 8));
      chk("R8", "cmd7 clr", s_isr_clr, 8'(1) << ((ln + 3) % 8));
      chk("R8", "cmd7 base", rot_base_o, (ln + 4) % 8);
      cyc(1, 0, 0, 8'h40 | 8'(ln));
      chk("R8", "cmd2 clr", s_isr_clr, 0);
      chk("R8", "cmd2 base", rot_base_o, (ln + 4) % 8);
      chk("R8", "cmd2 mask", mask_o, 8'h3C);
    end

    // R11 async reset mid-run
    @(negedge clk_i); rst_ni = 1'b0; #1;
    chk("R11", "async", {mask_o, 5'(rot_base_o), rsel_o, smm_o}, 0);
    rst_ni = 1'b1;
    cyc(1, 0, 1, 8'h81);
    chk("R11", "run after reset", mask_o, 8'h81);
    finish_run();
  end
endmodule